// File: doc/BRIEF.md
# Receive Lane-Order Restorer

This block sits in a receive datapath that carries two 16-bit lanes per parallel word: an upper lane in bits [31:16] and a lower lane in bits [15:0]. The 16-bit symbols travel in a fixed order. Within a word the upper lane comes first and the lower lane comes second. After serial-to-parallel conversion, the symbol that opens a frame can land in either lane. The block puts it back in the upper lane.

Software or control logic starts a realignment by raising the arm input. The block then searches each valid word for a programmable 16-bit marker. When the marker sits in the upper lane, the stream passes through unchanged. When it sits in the lower lane, the block inserts a programmable 16-bit pad symbol ahead of it. This shifts the whole stream by one lane, and from then on each output word is built from one held lane plus the new upper lane. A status output reports that ordering has finished. The block does no further searching until the next rising edge of the arm input.

Top module: `rx_lane_order`

## Requirements
- R1: While reset is high, and on the first cycle after reset, out_valid, order_done and out_data are all zero.
- R2: out_valid equals in_valid of the previous cycle, with one register stage. When in_valid is low, out_data keeps its previous value, and that word is neither searched nor used to update the held lane.
- R3: In direct mode, each valid word appears on out_data one cycle later, unchanged. Direct mode applies after reset and after every arming event.
- R4: Arming happens when arm_en is high in a cycle after a cycle in which it was low. The word in the arming cycle is handled in the previous mode and is not searched. In the next cycle, order_done reads 0, the held lane is discarded, direct mode resumes, and searching starts with the following valid word.
- R5: While searching, a valid word whose upper lane [31:16] equals order_pattern is passed unchanged. order_done goes high in the same cycle as that output word.
- R6: While searching, a valid word whose lower lane [15:0] equals order_pattern and whose upper lane does not is output as {upper lane, pad_word}. order_done goes high with that word, and the block enters merged mode.
- R7: When both lanes of a searched word equal order_pattern, the upper-lane match wins, and no pad is inserted.
- R8: In merged mode, each valid word is output as {lower lane of the previous valid word, upper lane of the current word}. The pattern that caused the pad therefore appears in the upper lane of the next output word.
- R9: Once order_done is high, it stays high and no further search takes place, whatever the data, until the next arming event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 32 | Input word, upper lane [31:16], lower lane [15:0] |
| arm_en | input | 1 | Realignment request; a rising edge arms a search |
| order_pattern | input | 16 | Marker symbol that must land in the upper lane |
| pad_word | input | 16 | Filler symbol inserted to shift the stream by one lane |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 32 | Ordered output word |
| order_done | output | 1 | High once ordering has completed since the last arming |

## Verification
The bench sends the marker in the arming cycle itself, where a design that searched too early would lock there and skip the later marker. It sends the marker in the lower lane after an idle gap, so that a design which dropped or refreshed the held lane on invalid cycles would emit a wrong merged word. It sends words carrying the marker in both lanes, where a wrong priority would insert an unwanted pad. It re-arms while in merged mode, where a design that kept the held lane would shift the next search. It also repeats the marker after lock, where a design that re-searched would clear or shift the stream again.

// File: rtl/rx_lane_order_pkg.sv
package rx_lane_order_pkg;
  typedef enum logic [1:0] {
    ORD_IDLE   = 2'd0,
    ORD_SEARCH = 2'd1,
    ORD_LOCKED = 2'd2
  } ord_state_e;
endpackage

// File: rtl/rlo_rise_detect.sv
module rlo_rise_detect (
  input  logic clk,
  input  logic sig,
  output logic rise
);
  // Tracks the input even during reset, so a level held through reset
  // is not mistaken for a fresh edge afterwards.
  logic sig_q = 1'b0;

  always_ff @(posedge clk) begin
    sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/rlo_lane_match.sv
module rlo_lane_match #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic [WORD_W-1:0] word,
  input  logic [LANE_W-1:0] pattern,
  output logic [LANES-1:0]  hit
);
  // hit[i] flags lane i, where lane 0 is the least-significant lane
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = (word[i*LANE_W +: LANE_W] == pattern);
  end
endmodule

// File: rtl/rlo_lane_merge.sv
module rlo_lane_merge #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              insert_pad,
  input  logic              merged,
  input  logic [LANE_W-1:0] pad_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [LANE_W-1:0] hold_q;
  logic [LANE_W-1:0] up_lane;
  logic [LANE_W-1:0] lo_lane;
  logic [WORD_W-1:0] next_word;

  assign up_lane = in_data[WORD_W-1:LANE_W];
  assign lo_lane = in_data[LANE_W-1:0];

  always_comb begin
    if (insert_pad) begin
      next_word = {up_lane, pad_word};
    end else if (merged) begin
      next_word = {hold_q, up_lane};
    end else begin
      next_word = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hold_q   <= lo_lane;
        out_data <= next_word;
      end
    end
  end
endmodule

// File: rtl/rx_lane_order.sv
module rx_lane_order
  import rx_lane_order_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              arm_en,
  input  logic [LANE_W-1:0] order_pattern,
  input  logic [LANE_W-1:0] pad_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              order_done
);
  ord_state_e state_q;
  logic       merged_q;
  logic       arm_rise;
  logic [1:0] lane_hit;
  logic       searching;
  logic       hit_up;
  logic       hit_lo;

  rlo_rise_detect u_rise (
    .clk  (clk),
    .sig  (arm_en),
    .rise (arm_rise)
  );

  rlo_lane_match #(.LANE_W(LANE_W), .LANES(2)) u_match (
    .word    (in_data),
    .pattern (order_pattern),
    .hit     (lane_hit)
  );

  // An arming edge takes priority: the word in that cycle is not searched
  assign searching = (state_q == ORD_SEARCH) && !arm_rise && in_valid;
  assign hit_up    = searching && lane_hit[1];
  assign hit_lo    = searching && !lane_hit[1] && lane_hit[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ORD_IDLE;
      merged_q   <= 1'b0;
      order_done <= 1'b0;
    end else if (arm_rise) begin
      state_q    <= ORD_SEARCH;
      merged_q   <= 1'b0;
      order_done <= 1'b0;
    end else if (hit_up) begin
      state_q    <= ORD_LOCKED;
      order_done <= 1'b1;
    end else if (hit_lo) begin
      state_q    <= ORD_LOCKED;
      merged_q   <= 1'b1;
      order_done <= 1'b1;
    end
  end

  rlo_lane_merge #(.LANE_W(LANE_W)) u_merge (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .insert_pad (hit_lo),
    .merged     (merged_q),
    .pad_word   (pad_word),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );
endmodule

// File: rtl/rx_lane_order_chk.sv
module rx_lane_order_chk #(
  parameter int LANE_W = 16,
  localparam int WORD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              arm_en,
  input logic [LANE_W-1:0] order_pattern,
  input logic [LANE_W-1:0] pad_word,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              order_done
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R4
  rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (arm_en && !$past(arm_en)) |=> !order_done);

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (order_done && !(arm_en && !$past(arm_en))) |=> order_done);

  // R5
  done_needs_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(order_done) |-> $past(in_valid));

  // R6
  done_word_shape_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(order_done) |-> (out_data[WORD_W-1:LANE_W] == order_pattern ||
                           out_data[LANE_W-1:0] == pad_word));
endmodule

bind rx_lane_order rx_lane_order_chk #(.LANE_W(LANE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .arm_en        (arm_en),
  .order_pattern (order_pattern),
  .pad_word      (pad_word),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .order_done    (order_done)
);

// File: tb/rx_lane_order_test.sv
module rx_lane_order_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_data;
  logic        arm_en;
  logic [15:0] order_pattern;
  logic [15:0] pad_word;
  logic        out_valid;
  logic [31:0] out_data;
  logic        order_done;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [15:0] q[$];
  bit          m_en_q;
  bit          m_srch;
  bit          m_done;
  bit          exp_valid;
  logic [31:0] exp_data;

  always #2 clk = ~clk;

  rx_lane_order uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .arm_en(arm_en), .order_pattern(order_pattern), .pad_word(pad_word),
    .out_valid(out_valid), .out_data(out_data), .order_done(order_done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    check(req, "out_valid", {31'd0, out_valid}, {31'd0, exp_valid});
    check(req, "order_done", {31'd0, order_done}, {31'd0, m_done});
    check(req, "out_data", out_data, exp_data);
  endtask

  task automatic model(input bit v, input logic [31:0] d, input bit en);
    bit rise;
    logic [15:0] up, lo, a, b;
    rise = en && !m_en_q;
    m_en_q = en;
    if (v) begin
      up = d[31:16];
      lo = d[15:0];
      if (m_srch && !rise && up == order_pattern) begin
        q.push_back(up); q.push_back(lo);
        m_srch = 0; m_done = 1;
      end else if (m_srch && !rise && lo == order_pattern) begin
        q.push_back(up); q.push_back(pad_word); q.push_back(lo);
        m_srch = 0; m_done = 1;
      end else begin
        q.push_back(up); q.push_back(lo);
      end
      a = q.pop_front();
      b = q.pop_front();
      exp_data = {a, b};
    end
    exp_valid = v;
    if (rise) begin
      m_srch = 1; m_done = 0; q.delete();
    end
  endtask

  task automatic step(input bit v, input logic [31:0] d, input bit en,
                      input string req);
    @(negedge clk);
    in_valid = v; in_data = d; arm_en = en;
    model(v, d, en);
    @(posedge clk);
    #1;
    compare_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] P;
    P = 16'hBC50;
    order_pattern = P;
    pad_word = 16'h0F0F;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; arm_en = 1'b0;
    m_en_q = 0; m_srch = 0; m_done = 0; exp_valid = 0; exp_data = '0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    compare_all("R1");

    // direct mode before any arming
    step(1, 32'h1111_2222, 0, "R3");
    step(0, 32'hDEAD_BEEF, 0, "R2");
    step(1, 32'h3333_4444, 0, "R3");

    // arming cycle carries the marker: must not be searched
    step(1, {P, 16'h1234}, 1, "R4");
    step(1, 32'h5555_6666, 1, "R4");
    step(0, {P, P}, 1, "R2");
    step(1, {P, 16'h7777}, 1, "R5");
    step(1, {16'h8888, P}, 1, "R9");
    step(1, {P, P}, 0, "R9");

    // re-arm, marker in lower lane -> pad, then merged mode
    step(1, 32'h9999_AAAA, 1, "R4");
    step(1, {16'h1357, P}, 1, "R6");
    step(1, 32'h2468_ACE0, 1, "R8");
    step(0, 32'hFFFF_0000, 1, "R2");
    step(1, 32'hBEEF_CAFE, 1, "R8");
    step(1, {P, 16'h0001}, 1, "R9");

    // re-arm while merged: arming word still merged, then direct
    step(0, 32'h0, 0, "R2");
    step(1, 32'h1111_2222, 1, "R4");
    step(1, 32'h3333_4444, 1, "R3");
    step(1, {P, P}, 1, "R7");
    step(1, 32'h5555_6666, 1, "R7");

    // enable held high: no new search, done stays
    step(1, {16'h4242, P}, 1, "R9");
    step(1, 32'h7777_8888, 1, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule